// File: doc/BRIEF.md
# Serial Converter Code Loader

This block is the digital front end of a serially loaded 12-bit converter. A host drives five pins: an active-low select, a serial clock, serial data, an active-low load strobe and an active-low clear. A fast system clock samples all five pins. The block moves serial bits into a shift register and copies that register into a holding register. The holding register drives the code bus that would feed the converter core.

The host can load a new word into the shift register while the held code stays unchanged. It then commits the word with the load strobe. The clear pin drives the held code to zero at any time. The pins are taken to be asynchronous to the system clock. Each pin passes through a two-stage synchronizer before any edge is detected. Because of this, the held code follows a pin change a few system clocks later.

Top module: `sdac_front`

## Requirements
- R1: While select is low, each rising edge of the serial clock shifts the data bit into the least significant position of the shift register. Bits arrive most significant bit first, so after 12 clocks the first bit sent is code bit 11.
- R2: A rising edge of select while the serial clock is high shifts exactly one data bit into the shift register.
- R3: While select stays high, serial clock edges and data changes leave the shift register unchanged.
- R4: A falling edge of the load strobe, with clear high, copies the shift register into the held code.
- R5: While the load strobe stays low and clear is high, the held code follows every change of the shift register.
- R6: While clear is low, the held code is zero, whatever the level of the load strobe.
- R7: After clear rises while the load strobe is high, the held code stays zero until the next load.
- R8: When more than 12 bits are clocked in, only the last 12 are kept. A 16-bit transfer of 0xBEEF leaves 0xEEF.
- R9: While the load strobe and clear are both high, shifting does not change the held code.
- R10: Reset sets the shift register and the held code to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select pin |
| ser_clk | input | 1 | Serial clock pin |
| ser_dat | input | 1 | Serial data pin |
| load_n | input | 1 | Active-low load strobe pin |
| clear_n | input | 1 | Active-low clear pin |
| code | output | 12 | Held converter code |

## Verification
The assertions check on every cycle the rules that one register step decides:
- a qualifying clock or select edge enters the new bit at the bottom of the shift register;
- a held-high select freezes the shift register;
- clear gives zero on the next cycle;
- a low strobe makes the held code track the shift register;
- strobe and clear both high freeze the held code.

Only the bench scenarios can show the results over whole transfers:
- the most-significant-first order across a full word;
- the 16-bit overflow that drops the oldest bits;
- zeros that stay latched after clear is released;
- a pending word that reaches the code only when the strobe falls.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int unsigned CODE_W_DEF = 12;
  parameter int unsigned SYNC_DEF   = 2;

  // synchronized pin bundle
  typedef struct packed {
    logic sel_n;
    logic sclk;
    logic sdat;
    logic load_n;
    logic clear_n;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  // idle levels the synchronizer takes in reset: select, load and clear high
  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, sdat: 1'b0,
                                  load_n: 1'b1, clear_n: 1'b1};
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_nxt;
    always_comb begin
      chain_nxt = {chain[b][STAGES-2:0], d_in[b]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[b] <= {STAGES{RST_VAL[b]}};
      end else begin
        chain[b] <= chain_nxt;
      end
    end
    assign d_out[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         sclk,
  input  logic         sdat,
  output logic [W-1:0] shreg
);
  logic         sel_q, sclk_q;
  logic         step;
  logic [W-1:0] shreg_nxt;

  // a step is taken on a serial clock rise while selected, or on a select rise while the clock is high
  always_comb begin
    step      = (sclk & ~sclk_q & ~sel_n) | (sel_n & ~sel_q & sclk);
    shreg_nxt = shreg;
    if (step) begin
      shreg_nxt = {shreg[W-2:0], sdat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
      shreg  <= '0;
    end else begin
      sel_q  <= sel_n;
      sclk_q <= sclk;
      if (step) begin
        shreg <= shreg_nxt;
      end
    end
  end

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !sel_n) |=> (shreg == {$past(shreg[W-2:0]), $past(sdat)})); // R1
  AST_SELECT_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel_n) && sclk) |=> (shreg[0] == $past(sdat))); // R2
  AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && $stable(sel_n)) |=> $stable(shreg)); // R3
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         clear_n,
  input  logic [W-1:0] shreg,
  output logic [W-1:0] held
);
  logic [W-1:0] held_nxt;
  logic         held_en;

  // clear has priority; a low strobe makes the register follow the shift register
  always_comb begin
    held_en  = ~clear_n | ~load_n;
    held_nxt = clear_n ? shreg : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (held_en) begin
      held <= held_nxt;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (held == '0)); // R6
  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && clear_n) |=> (held == $past(shreg))); // R5
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && clear_n) |=> $stable(held)); // R9
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [CODE_W-1:0] code
);
  pins_t        pins_raw, pins_s;
  logic [CODE_W-1:0] shreg;

  always_comb begin
    pins_raw = '{sel_n: sel_n, sclk: ser_clk, sdat: ser_dat,
                 load_n: load_n, clear_n: clear_n};
  end

  sdac_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pins_raw),
    .d_out(pins_s)
  );

  sdac_shift #(.W(CODE_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .sel_n(pins_s.sel_n),
    .sclk (pins_s.sclk),
    .sdat (pins_s.sdat),
    .shreg(shreg)
  );

  sdac_hold #(.W(CODE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (pins_s.load_n),
    .clear_n(pins_s.clear_n),
    .shreg  (shreg),
    .held   (code)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (code == '0)); // R10
endmodule

// File: tb/sdac_front_test.sv
`timescale 1ns/1ps
module sdac_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic [11:0] code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_sh   = '0;
  logic [11:0] m_hold = '0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sdac_front uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .load_n(load_n), .clear_n(clear_n), .code(code)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard entry: expected held code after the pins settle
  task automatic expect_code(string tag);
    tick(6);
    @(posedge clk);
    exp_q.push_back(m_hold);
    tag_q.push_back(tag);
  endtask

  task automatic clk_bit(bit b);
    ser_dat = b;
    tick(3);
    ser_clk = 1'b1;
    tick(3);
    ser_clk = 1'b0;
    tick(3);
    if (!sel_n) m_sh = {m_sh[10:0], b};
    if (!load_n && clear_n) m_hold = m_sh;
  endtask

  task automatic send(logic [15:0] val, int nbits);
    sel_n = 1'b0;
    tick(3);
    for (int i = nbits - 1; i >= 0; i--) clk_bit(val[i]);
    sel_n = 1'b1;
    tick(3);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    tick(4);
    m_hold = clear_n ? m_sh : 12'h000;
    load_n = 1'b1;
    tick(4);
  endtask

  // monitor: compares each queued expectation against the code output
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (code !== e) begin
        errors++;
        $display("FAIL %s: code=%03h expected=%03h", t, code, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    expect_code("R10 reset");

    // word loads with strobe high: held code untouched until the strobe falls
    send(16'h0A5C, 12);
    expect_code("R9 pending word");
    pulse_load();
    expect_code("R1 R4 first word");

    send(16'h03F0, 12);
    expect_code("R9 second pending");
    pulse_load();
    expect_code("R4 second word");

    // select high: clock activity must not reach the shift register
    ser_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(3); ser_clk = 1'b1; tick(3); ser_clk = 1'b0;
    end
    tick(3);
    pulse_load();
    expect_code("R3 deselected clocks");

    // overflow: only the last 12 bits stay
    send(16'hBEEF, 16);
    pulse_load();
    expect_code("R8 16-bit transfer");

    // select rising while serial clock high shifts one bit
    ser_dat = 1'b1;
    tick(3); ser_clk = 1'b1; tick(3);
    sel_n = 1'b0; tick(4);
    sel_n = 1'b1; tick(4);
    m_sh = {m_sh[10:0], 1'b1};
    ser_clk = 1'b0; tick(4);
    pulse_load();
    expect_code("R2 select-edge shift");

    // transparent strobe
    load_n = 1'b0;
    tick(4);
    m_hold = m_sh;
    sel_n = 1'b0;
    tick(3);
    clk_bit(1'b0); expect_code("R5 follow bit a");
    clk_bit(1'b1); expect_code("R5 follow bit b");
    clk_bit(1'b1); expect_code("R5 follow bit c");
    sel_n = 1'b1;
    load_n = 1'b1;
    tick(4);

    // clear behaviour
    clear_n = 1'b0;
    m_hold = 12'h000;
    expect_code("R6 clear with strobe high");
    load_n = 1'b0;
    expect_code("R6 clear with strobe low");
    load_n = 1'b1;
    tick(4);
    clear_n = 1'b1;
    expect_code("R7 zeros latched");
    send(16'h0123, 12);
    expect_code("R7 R9 zeros after shifting");
    pulse_load();
    expect_code("R4 load after clear");

    tick(4);
    wait (exp_q.size() == 0);
    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule